// File: doc/BRIEF.md
# DMA Channel Address and Count Registers

This block keeps the address and transfer-count state for one DMA channel of the legacy style. Each of the two 16-bit quantities exists twice. A base copy holds the value software programmed. A current copy moves as transfers complete. Software reaches both quantities through an 8-bit register port. A byte-pointer flip-flop chooses whether the low or the high half is touched. A write lands in both copies, and a read returns only the current copy.

The channel controller pulses `xfer` once per completed transfer. On each accepted pulse, the current address moves up or down by one and the current count drops by one. The transfer that finds the count at zero is the terminal one. It wraps the count to all ones and raises a terminal-count pulse, so programming N gives N+1 transfers. With auto-initialize set, the terminal transfer reloads both current registers from their base copies. Without it, the channel halts until the count is written again. The bus address is presented directly for byte channels, or shifted left by one for word channels.

Top module: `dma_chan_regs`

## Requirements
- R1: A host write (`reg_wr`) stores `wr_data` into the byte of the base register chosen by the pointer and into the same byte of the current register. `reg_sel` = 0 selects the address register and 1 selects the count register.
- R2: `rd_data` returns the byte of the current register (never the base) chosen by the pointer. It is combinational from the current state. Pointer 0 selects bits 7:0 and pointer 1 selects bits 15:8.
- R3: The byte pointer toggles after every cycle with `reg_rd` or `reg_wr` high. It returns to 0 on `ptr_clr` (which wins over a toggle) and on reset.
- R4: Each accepted transfer adds 1 to the current address when `addr_dec` = 0 and subtracts 1 when `addr_dec` = 1. The address wraps modulo 65536.
- R5: Each accepted transfer decrements the current count. The transfer that finds the count at 0 is terminal and wraps the count to FFFFh, so a programmed N gives exactly N+1 transfers. `tc_pulse` is high for the single cycle after the terminal transfer's clock edge.
- R6: `tc_flag` becomes 1 at a terminal transfer and stays set. It is cleared by a write to either count byte or by reset.
- R7: With `auto_init` = 1, the terminal transfer loads the current address and current count from their base registers instead of stepping them.
- R8: With `auto_init` = 0, transfers after a terminal transfer leave address and count unchanged until a count byte is written.
- R9: A transfer strobe in the same cycle as any host write is dropped. Only the write takes effect.
- R10: With `WIDE_CHAN` = 0, `bus_addr` is {0, current address}. With `WIDE_CHAN` = 1, it is {current address, 0}.
- R11: After reset, all four registers are 0, the pointer is 0, and `tc_pulse`, `tc_flag` and the halt state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = address register, 1 = count register |
| reg_wr | input | 1 | Host byte write strobe |
| reg_rd | input | 1 | Host byte read strobe (advances the pointer) |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Selected byte of the selected current register |
| ptr_clr | input | 1 | Byte pointer clear strobe |
| xfer | input | 1 | One completed transfer |
| addr_dec | input | 1 | 1 = address decrements per transfer |
| auto_init | input | 1 | Reload from base on terminal count |
| bus_addr | output | 17 | Address presented to the bus |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| tc_flag | output | 1 | Sticky terminal-count status |

## Verification
Register writes, pointer moves and transfer steps all take effect at the clock edge where the strobe is high. `rd_data` and `bus_addr` are combinational from that state, so they are valid one cycle after the strobe. `tc_pulse` is registered and is visible in exactly the cycle after the terminal transfer's edge. The bench drives every strobe for one cycle from a falling edge and samples at the next falling edge. Each check therefore falls in the cycle where its result is due, and the terminal pulse is counted once per transfer cycle so that a pulse arriving one transfer early or late shows up. Sweeps over programmed counts and both address directions, including a wrap through zero, compare against values computed in the bench.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic {
      SEL_ADDR  = 1'b0,
      SEL_COUNT = 1'b1
   } dma_reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic access,
   output logic hi
);
   always_ff @(posedge clk) begin
      if (!rst_n)      hi <= 1'b0;
      else if (clr)    hi <= 1'b0;
      else if (access) hi <= ~hi;
   end

   // R3
   ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !clr) |=> (hi != $past(hi)));
   // R3
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !hi);
endmodule

// File: rtl/dma_step_reg.sv
module dma_step_reg #(
   parameter int REG_W  = 16,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              byte_hi,
   input  logic [PORT_W-1:0] wr_data,
   input  logic              step_en,
   input  logic              step_dn,
   input  logic              reload,
   output logic [REG_W-1:0]  cur_q
);
   localparam int NLANE = REG_W / PORT_W;

   logic [REG_W-1:0] base_q;
   logic [REG_W-1:0] stepped;

   assign stepped = step_dn ? cur_q - REG_W'(1) : cur_q + REG_W'(1);

   for (genvar b = 0; b < NLANE; b++) begin : g_lane
      logic lane_we;
      assign lane_we = wr_en && (byte_hi == b[0]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[b*PORT_W +: PORT_W] <= '0;
            cur_q[b*PORT_W +: PORT_W]  <= '0;
         end else if (lane_we) begin
            base_q[b*PORT_W +: PORT_W] <= wr_data;
            cur_q[b*PORT_W +: PORT_W]  <= wr_data;
         end else if (!wr_en && reload) begin
            cur_q[b*PORT_W +: PORT_W]  <= base_q[b*PORT_W +: PORT_W];
         end else if (!wr_en && step_en) begin
            cur_q[b*PORT_W +: PORT_W]  <= stepped[b*PORT_W +: PORT_W];
         end
      end
   end

   // R1
   wr_low_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !byte_hi) |=> (cur_q[PORT_W-1:0] == $past(wr_data)) &&
                              (base_q[PORT_W-1:0] == $past(wr_data)));
   // R1
   wr_high_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_hi) |=> (cur_q[REG_W-1 -: PORT_W] == $past(wr_data)) &&
                             (base_q[REG_W-1 -: PORT_W] == $past(wr_data)));
   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_en) |=> (cur_q == $past(base_q)));
   // R4
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !reload && !wr_en && !step_dn) |=> (cur_q == $past(cur_q) + REG_W'(1)));
   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !reload && !wr_en && step_dn) |=> (cur_q == $past(cur_q) - REG_W'(1)));
endmodule

// File: rtl/dma_bus_addr.sv
module dma_bus_addr #(
   parameter int REG_W = 16,
   parameter bit WIDE  = 1'b0
) (
   input  logic [REG_W-1:0] cur_addr,
   output logic [REG_W:0]   bus_addr
);
   if (WIDE) begin : g_word
      assign bus_addr = {cur_addr, 1'b0};
   end else begin : g_byte
      assign bus_addr = {1'b0, cur_addr};
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int REG_W     = 16,
   parameter int PORT_W    = 8,
   parameter bit WIDE_CHAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [PORT_W-1:0] wr_data,
   output logic [PORT_W-1:0] rd_data,
   input  logic              ptr_clr,
   input  logic              xfer,
   input  logic              addr_dec,
   input  logic              auto_init,
   output logic [REG_W:0]    bus_addr,
   output logic              tc_pulse,
   output logic              tc_flag
);
   import dma_chan_pkg::*;

   localparam int BUS_W = REG_W + 1;

   if (REG_W != 2 * PORT_W) begin : g_bad_width
      $error("dma_chan_regs: REG_W must be twice PORT_W");
   end

   dma_reg_sel_e     sel;
   logic             ptr_hi;
   logic             addr_we, cnt_we;
   logic             halted, accept, at_tc, reload;
   logic [REG_W-1:0] addr_cur, cnt_cur, sel_cur;

   assign sel     = dma_reg_sel_e'(reg_sel);
   assign addr_we = reg_wr && (sel == SEL_ADDR);
   assign cnt_we  = reg_wr && (sel == SEL_COUNT);
   assign accept  = xfer && !halted && !reg_wr;
   assign at_tc   = accept && (cnt_cur == '0);
   assign reload  = at_tc && auto_init;

   dma_byte_ptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ptr_clr),
      .access (reg_rd | reg_wr),
      .hi     (ptr_hi)
   );

   dma_step_reg #(.REG_W(REG_W), .PORT_W(PORT_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (addr_we),
      .byte_hi (ptr_hi),
      .wr_data (wr_data),
      .step_en (accept),
      .step_dn (addr_dec),
      .reload  (reload),
      .cur_q   (addr_cur)
   );

   dma_step_reg #(.REG_W(REG_W), .PORT_W(PORT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cnt_we),
      .byte_hi (ptr_hi),
      .wr_data (wr_data),
      .step_en (accept),
      .step_dn (1'b1),
      .reload  (reload),
      .cur_q   (cnt_cur)
   );

   dma_bus_addr #(.REG_W(REG_W), .WIDE(WIDE_CHAN)) u_bus (
      .cur_addr (addr_cur),
      .bus_addr (bus_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted   <= 1'b0;
         tc_flag  <= 1'b0;
         tc_pulse <= 1'b0;
      end else begin
         tc_pulse <= at_tc;
         if (cnt_we) begin
            halted  <= 1'b0;
            tc_flag <= 1'b0;
         end else if (at_tc) begin
            halted  <= !auto_init;
            tc_flag <= 1'b1;
         end
      end
   end

   assign sel_cur = (sel == SEL_COUNT) ? cnt_cur : addr_cur;
   assign rd_data = ptr_hi ? sel_cur[REG_W-1 -: PORT_W] : sel_cur[PORT_W-1:0];

   // R6
   tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> tc_flag);
   // R8
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !reg_wr) |=> ($stable(cnt_cur) && $stable(addr_cur)));
   // R9
   wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && addr_we) |=> $stable(cnt_cur));
   // R10
   bus_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($bits(bus_addr) == BUS_W) && (WIDE_CHAN ? !bus_addr[0] : !bus_addr[REG_W]));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, ptr_clr = 1'b0;
   logic xfer = 1'b0, addr_dec = 1'b0, auto_init = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data, rd_data_w;
   logic [16:0] bus_addr, bus_addr_w;
   logic tc_pulse, tc_flag, tc_pulse_w, tc_flag_w;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dma_chan_regs #(.WIDE_CHAN(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .wr_data(wr_data), .rd_data(rd_data), .ptr_clr(ptr_clr), .xfer(xfer),
      .addr_dec(addr_dec), .auto_init(auto_init), .bus_addr(bus_addr),
      .tc_pulse(tc_pulse), .tc_flag(tc_flag));

   dma_chan_regs #(.WIDE_CHAN(1'b1)) u_dut_wide (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .wr_data(wr_data), .rd_data(rd_data_w), .ptr_clr(ptr_clr), .xfer(xfer),
      .addr_dec(addr_dec), .auto_init(auto_init), .bus_addr(bus_addr_w),
      .tc_pulse(tc_pulse_w), .tc_flag(tc_flag_w));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr_ptr();
      @(negedge clk) ptr_clr = 1'b1;
      @(negedge clk) ptr_clr = 1'b0;
   endtask

   task automatic wr_byte(logic sel, logic [7:0] d);
      @(negedge clk) begin reg_sel = sel; reg_wr = 1'b1; wr_data = d; end
      @(negedge clk) reg_wr = 1'b0;
   endtask

   task automatic rd_byte(logic sel, output logic [7:0] d);
      @(negedge clk) begin reg_sel = sel; reg_rd = 1'b1; end
      #1 d = rd_data;
      @(negedge clk) reg_rd = 1'b0;
   endtask

   task automatic wr16(logic sel, logic [15:0] v);
      clr_ptr();
      wr_byte(sel, v[7:0]);
      wr_byte(sel, v[15:8]);
   endtask

   task automatic rd16(logic sel, output logic [15:0] v);
      logic [7:0] lo, hi;
      clr_ptr();
      rd_byte(sel, lo);
      rd_byte(sel, hi);
      v = {hi, lo};
   endtask

   // one transfer; returns tc_pulse seen in the cycle after the edge
   task automatic do_xfer(output logic tc);
      @(negedge clk) xfer = 1'b1;
      @(negedge clk) xfer = 1'b0;
      tc = tc_pulse;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v, exp_a;
      logic [7:0] b;
      logic tc;
      int pulses, at;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 tc_flag", tc_flag, 0);
      check("R11 tc_pulse", tc_pulse, 0);
      check("R11 bus_addr", bus_addr, 0);
      rd_byte(1'b1, b);
      check("R11 count low after reset, pointer low", b, 8'h00);

      // R1 R2 write then read both bytes in pointer order
      wr16(1'b0, 16'h1234);
      rd16(1'b0, v);
      check("R1 R2 address readback", v, 16'h1234);
      wr16(1'b1, 16'hBEEF);
      rd16(1'b1, v);
      check("R1 R2 count readback", v, 16'hBEEF);

      // R3 clear mid-sequence selects low byte again
      clr_ptr();
      wr_byte(1'b0, 8'hAB);
      clr_ptr();
      rd_byte(1'b0, b);
      check("R3 clear returns pointer to low byte", b, 8'hAB);
      rd_byte(1'b0, b);
      check("R3 toggle after read selects high byte", b, 8'h12);

      // R4 R5 R6 R8 R10 sweep counts and directions
      for (int dir = 0; dir < 2; dir++) begin
         for (int n = 0; n < 6; n++) begin
            logic [15:0] a0;
            a0 = (dir == 0) ? 16'hFFFD : 16'h0002;
            addr_dec = dir[0];
            wr16(1'b0, a0);
            wr16(1'b1, 16'(n));
            check("R6 count write clears flag", tc_flag, 0);
            pulses = 0; at = -1;
            for (int k = 0; k <= n; k++) begin
               do_xfer(tc);
               if (tc) begin pulses++; at = k; end
            end
            check("R5 one terminal pulse", pulses, 1);
            check("R5 pulse on transfer N+1", at, n);
            check("R6 sticky flag", tc_flag, 1);
            exp_a = (dir == 0) ? a0 + 16'(n + 1) : a0 - 16'(n + 1);
            check("R10 byte channel bus address", bus_addr, {1'b0, exp_a});
            check("R10 word channel bus address", bus_addr_w, {exp_a, 1'b0});
            do_xfer(tc);
            check("R8 no pulse while halted", tc, 0);
            rd16(1'b0, v);
            check("R4 R8 address after run", v, exp_a);
            rd16(1'b1, v);
            check("R5 R8 count wrapped to FFFF", v, 16'hFFFF);
            check("R6 flag holds", tc_flag, 1);
         end
      end
      addr_dec = 1'b0;

      // R7 auto-initialize reload
      auto_init = 1'b1;
      wr16(1'b0, 16'h0100);
      wr16(1'b1, 16'h0002);
      pulses = 0;
      for (int k = 0; k < 3; k++) begin
         do_xfer(tc);
         if (tc) pulses++;
      end
      check("R7 pulse on reload", pulses, 1);
      rd16(1'b0, v);
      check("R7 address reloaded", v, 16'h0100);
      rd16(1'b1, v);
      check("R7 count reloaded", v, 16'h0002);
      do_xfer(tc);
      rd16(1'b1, v);
      check("R7 keeps running after reload", v, 16'h0001);
      check("R7 address steps after reload", bus_addr, 17'h00101);
      auto_init = 1'b0;

      // R9 write and transfer in the same cycle
      wr16(1'b1, 16'h0005);
      wr16(1'b0, 16'h4000);
      clr_ptr();
      @(negedge clk) begin reg_sel = 1'b0; reg_wr = 1'b1; wr_data = 8'h77; xfer = 1'b1; end
      @(negedge clk) begin reg_wr = 1'b0; xfer = 1'b0; end
      rd16(1'b0, v);
      check("R9 write wins, no step", v, 16'h4077);
      rd16(1'b1, v);
      check("R9 count not stepped", v, 16'h0005);

      // R6 single count byte write clears flag
      wr16(1'b1, 16'h0000);
      do_xfer(tc);
      check("R6 flag set", tc_flag, 1);
      clr_ptr();
      wr_byte(1'b1, 8'h03);
      check("R6 one byte write clears flag", tc_flag, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule